// File: doc/BRIEF.md
# Byte-Addressable General Register File

This block holds the eight 16-bit working registers of a 16-bit processor core: accumulator, count, data and base registers, plus stack pointer, frame (base) pointer, source index and destination index. Each of the first four can also be used as two independent 8-bit registers, a low half and a high half. The other four are word-only.

The execution datapath reaches the file through two read ports and one main write port. Each port takes a 3-bit register code and a width bit that selects byte or word access. Shift, rotate and loop sequencing need the iteration count on every cycle, so the count register is always visible on a dedicated output. Multiply and divide produce a second result word. That word goes into the data register through its own write port, which can be used in the same cycle as a main-port write of the accumulator.

Reads are combinational and show the contents from before any write in the same cycle. A write takes effect at the clock edge. Reset is asserted asynchronously, active low, and is released in step with the clock.

Top module: `gp_regfile`

## Requirements
- R1: While reset is held, and after it is released, every register reads as zero on both read ports in word mode.
- R2: A word write (width bit 0) to any code 0 to 7 stores all 16 bits. Word codes are 0 accumulator, 1 count, 2 data, 3 base, 4 stack pointer, 5 frame pointer, 6 source index, 7 destination index. A word read of that code from the following cycle on returns the written value.
- R3: A byte read (width bit 1) with codes 0 to 3 returns the low half of the accumulator, count, data or base register. Codes 4 to 7 return the high half of the same four registers, in the same order. The byte is placed in bits 7:0 and bits 15:8 are zero.
- R4: A byte write takes the byte from bits 7:0 of the write data. Code bit 2 selects the half (0 low, 1 high) and code bits 1:0 select the register. The write changes only that half. The other half of the same register is unchanged.
- R5: A read of a register that is written in the same cycle returns the value it held before that write.
- R6: The two read ports work independently. In one cycle they may select different registers, different widths, or the same register.
- R7: The count output always equals the count register (word code 1). It changes only after a word write to code 1 or a byte write to code 1 or 5.
- R8: When the dedicated data write enable is high, the data register (word code 2) takes its 16-bit input at the clock edge. This may happen in the same cycle as a main-port write to another register. If both ports write the data register in the same cycle, the dedicated port wins for the whole word.
- R9: With both write enables low, no register changes, whatever the values on the other write inputs.
- R10: Driving reset low at any time clears all registers at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Main write port enable |
| wr_byte | input | 1 | Main write width: 1 byte, 0 word |
| wr_code | input | 3 | Main write register code |
| wr_data | input | 16 | Main write data (bits 7:0 for byte writes) |
| dat_wr_en | input | 1 | Dedicated data register write enable |
| dat_wr_data | input | 16 | Dedicated data register write value |
| rda_code | input | 3 | Read port A register code |
| rda_byte | input | 1 | Read port A width: 1 byte, 0 word |
| rda_data | output | 16 | Read port A data |
| rdb_code | input | 3 | Read port B register code |
| rdb_byte | input | 1 | Read port B width: 1 byte, 0 word |
| rdb_data | output | 16 | Read port B data |
| cnt_data | output | 16 | Count register, always visible |

## Verification
Every word code is loaded with a distinct value, and the same cycle is also read on one port while the other reads a neighbour. This separates the old value from the new one and catches any mix-up between codes. All eight byte codes are then read and written. Each write puts a non-zero byte in bits 15:8 of the write data and a non-zero value in the other half of the target register, so a wrong half, a lost neighbour byte or a wrong source byte each give a different result. The dedicated data port is driven alone, together with an accumulator write, and against a main-port word write and a byte write of the data register. The bench also drives cycles with toggling write inputs but no enable, and a reset asserted in the middle of the run.

// File: rtl/gp_rf_pkg.sv
package gp_rf_pkg;

  // Word-mode register codes; byte codes reuse bits 1:0 as register index
  // and bit 2 as half select for the first four entries.
  typedef enum logic [2:0] {
    RC_ACC = 3'd0,
    RC_CNT = 3'd1,
    RC_DAT = 3'd2,
    RC_BAS = 3'd3,
    RC_STK = 3'd4,
    RC_FRM = 3'd5,
    RC_SRC = 3'd6,
    RC_DST = 3'd7
  } reg_code_e;

  localparam int unsigned RF_DATA_W   = 16;
  localparam int unsigned RF_NUM_REGS = 8;
  localparam int unsigned RF_CNT_IDX  = 32'(RC_CNT);
  localparam int unsigned RF_DAT_IDX  = 32'(RC_DAT);

endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned CODE_W  = $clog2(NUM_REGS),
  localparam int unsigned HALF_W  = DATA_W / 2,
  localparam int unsigned SPLIT_N = NUM_REGS / 2
) (
  input  logic                wr_en,
  input  logic                wr_byte,
  input  logic [CODE_W-1:0]   wr_code,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [NUM_REGS-1:0] lo_en,
  output logic [NUM_REGS-1:0] hi_en,
  output logic [HALF_W-1:0]   lo_val,
  output logic [HALF_W-1:0]   hi_val
);

  logic [CODE_W-2:0] byte_idx;
  logic              byte_hi;

  assign byte_idx = wr_code[CODE_W-2:0];
  assign byte_hi  = wr_code[CODE_W-1];

  // Byte writes always source bits 7:0; word writes use both halves.
  assign lo_val = wr_data[HALF_W-1:0];
  assign hi_val = wr_byte ? wr_data[HALF_W-1:0] : wr_data[DATA_W-1:HALF_W];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    logic word_hit;
    assign word_hit = wr_en && !wr_byte && (wr_code == CODE_W'(i));
    if (i < SPLIT_N) begin : g_split
      logic byte_hit;
      assign byte_hit = wr_en && wr_byte && (byte_idx == (CODE_W-1)'(i));
      assign lo_en[i] = word_hit || (byte_hit && !byte_hi);
      assign hi_en[i] = word_hit || (byte_hit && byte_hi);
    end else begin : g_word
      assign lo_en[i] = word_hit;
      assign hi_en[i] = word_hit;
    end
  end

endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned CODE_W  = $clog2(NUM_REGS),
  localparam int unsigned HALF_W  = DATA_W / 2
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [CODE_W-1:0]               code,
  input  logic                            is_byte,
  output logic [DATA_W-1:0]               data
);

  logic [DATA_W-1:0] split_reg;
  logic [HALF_W-1:0] half_sel;

  always_comb begin
    split_reg = regs[code[CODE_W-2:0]];
    half_sel  = code[CODE_W-1] ? split_reg[DATA_W-1:HALF_W] : split_reg[HALF_W-1:0];
    if (is_byte) begin
      data = {{HALF_W{1'b0}}, half_sel};
    end else begin
      data = regs[code];
    end
  end

endmodule

// File: rtl/gp_regfile.sv
module gp_regfile
  import gp_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = RF_NUM_REGS,
  parameter int unsigned DATA_W   = RF_DATA_W,
  parameter int unsigned CNT_IDX  = RF_CNT_IDX,
  parameter int unsigned DAT_IDX  = RF_DAT_IDX,
  parameter int unsigned SYNC_N   = 2,
  localparam int unsigned CODE_W  = $clog2(NUM_REGS),
  localparam int unsigned HALF_W  = DATA_W / 2,
  localparam int unsigned RD_N    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_byte,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dat_wr_en,
  input  logic [DATA_W-1:0] dat_wr_data,
  input  logic [CODE_W-1:0] rda_code,
  input  logic              rda_byte,
  output logic [DATA_W-1:0] rda_data,
  input  logic [CODE_W-1:0] rdb_code,
  input  logic              rdb_byte,
  output logic [DATA_W-1:0] rdb_data,
  output logic [DATA_W-1:0] cnt_data
);

  logic                            rst_sync_n;
  logic [NUM_REGS-1:0]             lo_en;
  logic [NUM_REGS-1:0]             hi_en;
  logic [HALF_W-1:0]               lo_val;
  logic [HALF_W-1:0]               hi_val;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  logic [RD_N-1:0][CODE_W-1:0]     rd_code;
  logic [RD_N-1:0]                 rd_byte;
  logic [RD_N-1:0][DATA_W-1:0]     rd_data;

  rf_rst_sync #(.STAGES(SYNC_N)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  rf_wr_decode #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_wr_dec (
    .wr_en   (wr_en),
    .wr_byte (wr_byte),
    .wr_code (wr_code),
    .wr_data (wr_data),
    .lo_en   (lo_en),
    .hi_en   (hi_en),
    .lo_val  (lo_val),
    .hi_val  (hi_val)
  );

  // Storage: one register per entry, each half with its own enable.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic              ext_hit;
    logic              lo_we;
    logic              hi_we;
    logic              reg_ce;
    logic [HALF_W-1:0] lo_nx;
    logic [HALF_W-1:0] hi_nx;
    logic [DATA_W-1:0] val_d;
    logic [DATA_W-1:0] val_q;

    assign ext_hit = dat_wr_en && (i == DAT_IDX);

    always_comb begin
      lo_we  = lo_en[i] || ext_hit;
      hi_we  = hi_en[i] || ext_hit;
      lo_nx  = ext_hit ? dat_wr_data[HALF_W-1:0]      : lo_val;
      hi_nx  = ext_hit ? dat_wr_data[DATA_W-1:HALF_W] : hi_val;
      reg_ce = lo_we || hi_we;
      val_d  = {hi_we ? hi_nx : val_q[DATA_W-1:HALF_W],
                lo_we ? lo_nx : val_q[HALF_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        val_q <= '0;
      end else if (reg_ce) begin
        val_q <= val_d;
      end
    end

    assign regs_q[i] = val_q;
  end

  assign rd_code = {rdb_code, rda_code};
  assign rd_byte = {rdb_byte, rda_byte};

  for (genvar p = 0; p < RD_N; p++) begin : g_rd
    rf_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_mux (
      .regs    (regs_q),
      .code    (rd_code[p]),
      .is_byte (rd_byte[p]),
      .data    (rd_data[p])
    );
  end

  assign rda_data = rd_data[0];
  assign rdb_data = rd_data[1];
  assign cnt_data = regs_q[CNT_IDX];

endmodule

// File: rtl/gp_regfile_chk.sv
module gp_regfile_chk #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_IDX  = 1,
  parameter int unsigned DAT_IDX  = 2,
  localparam int unsigned CODE_W  = $clog2(NUM_REGS),
  localparam int unsigned HALF_W  = DATA_W / 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic                            wr_byte,
  input logic [CODE_W-1:0]               wr_code,
  input logic [DATA_W-1:0]               wr_data,
  input logic                            dat_wr_en,
  input logic [DATA_W-1:0]               dat_wr_data,
  input logic                            rda_byte,
  input logic [DATA_W-1:0]               rda_data,
  input logic                            rdb_byte,
  input logic [DATA_W-1:0]               rdb_data,
  input logic [DATA_W-1:0]               cnt_data,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);

  logic [CODE_W-2:0] b_idx;
  logic              b_hi;
  logic [HALF_W-1:0] kept_half;
  logic              ext_clash_b;
  logic              ext_clash_w;
  logic              cnt_touch;

  always_comb begin
    b_idx       = wr_code[CODE_W-2:0];
    b_hi        = wr_code[CODE_W-1];
    kept_half   = b_hi ? regs_q[b_idx][HALF_W-1:0] : regs_q[b_idx][DATA_W-1:HALF_W];
    ext_clash_b = dat_wr_en && (b_idx == (CODE_W-1)'(DAT_IDX));
    ext_clash_w = dat_wr_en && (wr_code == CODE_W'(DAT_IDX));
    cnt_touch   = wr_en && (wr_byte ? (b_idx == (CODE_W-1)'(CNT_IDX))
                                    : (wr_code == CODE_W'(CNT_IDX)));
  end

  AST_WORD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_byte && !ext_clash_w) |=> regs_q[$past(wr_code)] == $past(wr_data)); // R2

  AST_BYTE_ZEXT_A: assert property (@(posedge clk) disable iff (!rst_n)
    rda_byte |-> rda_data[DATA_W-1:HALF_W] == '0); // R3

  AST_BYTE_ZEXT_B: assert property (@(posedge clk) disable iff (!rst_n)
    rdb_byte |-> rdb_data[DATA_W-1:HALF_W] == '0); // R3

  AST_BYTE_KEEPS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && !ext_clash_b) |=>
      (($past(b_hi) ? regs_q[$past(b_idx)][HALF_W-1:0]
                    : regs_q[$past(b_idx)][DATA_W-1:HALF_W]) == $past(kept_half))); // R4

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_touch |=> $stable(cnt_data)); // R7

  AST_DAT_PORT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr_en |=> regs_q[DAT_IDX] == $past(dat_wr_data)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !dat_wr_en) |=> $stable(regs_q)); // R9

endmodule

bind gp_regfile gp_regfile_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .CNT_IDX  (CNT_IDX),
  .DAT_IDX  (DAT_IDX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .wr_byte     (wr_byte),
  .wr_code     (wr_code),
  .wr_data     (wr_data),
  .dat_wr_en   (dat_wr_en),
  .dat_wr_data (dat_wr_data),
  .rda_byte    (rda_byte),
  .rda_data    (rda_data),
  .rdb_byte    (rdb_byte),
  .rdb_data    (rdb_data),
  .cnt_data    (cnt_data),
  .regs_q      (regs_q)
);

// File: tb/gp_regfile_tb_top.sv
module gp_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_byte, dat_wr_en, rda_byte, rdb_byte;
  logic [2:0]  wr_code, rda_code, rdb_code;
  logic [15:0] wr_data, dat_wr_data, rda_data, rdb_data, cnt_data;

  typedef struct {
    int          port;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t       sb_q[$];
  logic [15:0] model [8];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;

  always #2 clk = ~clk;

  gp_regfile dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_byte     (wr_byte),
    .wr_code     (wr_code),
    .wr_data     (wr_data),
    .dat_wr_en   (dat_wr_en),
    .dat_wr_data (dat_wr_data),
    .rda_code    (rda_code),
    .rda_byte    (rda_byte),
    .rda_data    (rda_data),
    .rdb_code    (rdb_code),
    .rdb_byte    (rdb_byte),
    .rdb_data    (rdb_data),
    .cnt_data    (cnt_data)
  );

  function automatic logic [15:0] model_rd(input logic [2:0] code, input logic is_byte);
    logic [15:0] w;
    if (!is_byte) return model[code];
    w = model[{1'b0, code[1:0]}];
    return code[2] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  // Driver: one call per cycle, at the falling edge.
  task automatic cyc(input logic we, input logic wb, input logic [2:0] wc,
                     input logic [15:0] wd, input logic xe, input logic [15:0] xd,
                     input logic [2:0] ac, input logic ab,
                     input logic [2:0] bc, input logic bb, input string req);
    item_t it;
    wr_en = we; wr_byte = wb; wr_code = wc; wr_data = wd;
    dat_wr_en = xe; dat_wr_data = xd;
    rda_code = ac; rda_byte = ab; rdb_code = bc; rdb_byte = bb;
    it.req = req;
    it.port = 0; it.exp = model_rd(ac, ab); sb_q.push_back(it);
    it.port = 1; it.exp = model_rd(bc, bb); sb_q.push_back(it);
    it.port = 2; it.exp = model[1];         sb_q.push_back(it);
    if (we) begin
      if (wb) begin
        if (wc[2]) model[{1'b0, wc[1:0]}][15:8] = wd[7:0];
        else       model[{1'b0, wc[1:0]}][7:0]  = wd[7:0];
      end else begin
        model[wc] = wd;
      end
    end
    if (xe) model[2] = xd;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] ac, input logic ab, input logic [2:0] bc,
                    input logic bb, input string req);
    cyc(1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 16'h0000, ac, ab, bc, bb, req);
  endtask

  // Monitor: compares the ports just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb_q.pop_front();
        act = (it.port == 0) ? rda_data : (it.port == 1) ? rdb_data : cnt_data;
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s port %0d: actual %h expected %h", it.req, it.port, act, it.exp);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_byte = 0; wr_code = 0; wr_data = 0;
    dat_wr_en = 0; dat_wr_data = 0;
    rda_code = 0; rda_byte = 0; rdb_code = 0; rdb_byte = 0;
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rd(3'd0, 1'b0, 3'd7, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: all zero after release
    for (int i = 0; i < 8; i++) rd(3'(i), 1'b0, 3'(7 - i), 1'b0, "R1");

    // R2/R5: word writes, same-cycle read of the target gives the old value
    for (int i = 0; i < 8; i++)
      cyc(1'b1, 1'b0, 3'(i), 16'hA05C ^ (16'h1357 * 16'(i + 1)), 1'b0, 16'h0,
          3'(i), 1'b0, 3'((i + 7) % 8), 1'b0, "R5");
    for (int i = 0; i < 8; i++) rd(3'(i), 1'b0, 3'(i), 1'b0, "R2");

    // R3: byte reads of every code on both ports
    for (int i = 0; i < 8; i++) rd(3'(i), 1'b1, 3'(7 - i), 1'b1, "R3");
    // R6: mixed widths, same register
    rd(3'd3, 1'b1, 3'd3, 1'b0, "R6");
    rd(3'd6, 1'b0, 3'd2, 1'b1, "R6");

    // R4: byte writes with junk in bits 15:8 of the write data
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b1, 3'(i), {8'hEE, 8'(8'h31 + 8'(i * 17))}, 1'b0, 16'h0,
          3'(i), 1'b1, 3'(i % 4), 1'b0, "R4");
      rd(3'(i % 4), 1'b0, 3'(i), 1'b1, "R4");
    end
    // R7: count register via its high byte and a word write
    cyc(1'b1, 1'b1, 3'd5, 16'h00C3, 1'b0, 16'h0, 3'd1, 1'b0, 3'd5, 1'b1, "R7");
    cyc(1'b1, 1'b0, 3'd1, 16'h0FF0, 1'b0, 16'h0, 3'd1, 1'b0, 3'd1, 1'b1, "R7");
    rd(3'd1, 1'b0, 3'd0, 1'b0, "R7");

    // R8: dedicated data port alone, with accumulator, and against the main port
    cyc(1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 16'h1234, 3'd2, 1'b0, 3'd0, 1'b0, "R8");
    cyc(1'b1, 1'b0, 3'd0, 16'hBEEF, 1'b1, 16'hCAFE, 3'd2, 1'b0, 3'd0, 1'b0, "R8");
    rd(3'd2, 1'b0, 3'd0, 1'b0, "R8");
    cyc(1'b1, 1'b0, 3'd2, 16'h5555, 1'b1, 16'h9A9A, 3'd2, 1'b0, 3'd6, 1'b1, "R8");
    rd(3'd2, 1'b0, 3'd2, 1'b1, "R8");
    cyc(1'b1, 1'b1, 3'd6, 16'h0077, 1'b1, 16'h4321, 3'd2, 1'b0, 3'd6, 1'b1, "R8");
    rd(3'd2, 1'b0, 3'd6, 1'b1, "R8");

    // R9: enables low, write inputs toggling
    for (int i = 0; i < 8; i++)
      cyc(1'b0, 1'(i % 2), 3'(i), 16'hFFFF - 16'(i), 1'b0, 16'h8888,
          3'(i), 1'b0, 3'(7 - i), 1'b0, "R9");
    for (int i = 0; i < 8; i++) rd(3'(i), 1'b0, 3'(i), 1'b1, "R9");

    // R10: reset asserted mid-run clears without a clock edge
    #0.5;
    rst_n = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 16'h0000;
    @(negedge clk);
    rd(3'd7, 1'b0, 3'd4, 1'b0, "R10");
    rd(3'd3, 1'b1, 3'd2, 1'b0, "R10");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) rd(3'(i), 1'b0, 3'(7 - i), 1'b0, "R10");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule